// File: doc/BRIEF.md
# Interrupt Status and Mask Register Unit

This block holds the interrupt bookkeeping of a serial flash controller. Five event inputs each set a sticky status flag: transfer done, transmit buffer empty, transmit buffer full, receive buffer empty and receive buffer full. Software reads the flags through a 32-bit register port and clears any of them by writing a 1 to its bit. A second register holds one blocking bit per source and a global blocking bit in its top position. The block combines these into a single registered, active-high interrupt line.

The register port is a simple single-cycle write with byte strobes and a registered read: the word addressed in one cycle appears on the read bus in the next cycle. Only two addresses decode. Every other address reads as zero, and writes to it are dropped.

Top module: `intr_regs_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all flags, all mask bits, `irq` and `rd_data` are 0.
- R2: A 1 on `evt_i[k]` sets flag k at the next clock edge, and the flag stays set until it is cleared. Bit 0 is transfer done, bit 1 is transmit empty, bit 2 is transmit full, bit 3 is receive empty and bit 4 is receive full. A flag never becomes set without its event.
- R3: A write to the status register (offset 0x0C) with strobe lane 0 set clears each flag whose `wr_data` bit in positions 4..0 is 1. Flags whose data bit is 0 are left unchanged.
- R4: When an event and a clearing write hit the same flag in the same cycle, the event wins and the flag remains set.
- R5: The mask register (offset 0x10) stores bits 4..0 as per-source blocks and bit 31 as the global block. Its reserved bits 30..5 read as 0 and ignore writes.
- R6: `irq` is registered. In each cycle it equals, one cycle late, the OR over k of (flag k AND NOT mask k), forced to 0 when the global mask bit is 1.
- R7: `rd_data` shows the register selected by the previous cycle's `rd_addr`: the status flags in bits 4..0 with the upper bits 0, the mask register as in R5, and 0 for any other address.
- R8: Byte strobes gate writes. Mask bits 4..0 and status clears need lane 0 (`wr_strb[0]`), and the global mask bit needs lane 3 (`wr_strb[3]`). A write without the needed lane leaves those bits unchanged.
- R9: Writes to any address other than 0x0C and 0x10 change no flag and no mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 5 | Event inputs, one per interrupt source |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| wr_strb | input | 4 | Byte lane strobes for the write |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Active-high interrupt line |

## Verification
The hardest case to reach from the ports is an event and a write-1-to-clear landing on the same flag in the same cycle. The result is hidden until a later read or a change on `irq`. The bench drives such a collision on purpose and then reads the status back. Its random phase draws events and status writes from independent streams with a high write rate to the two live addresses, so collisions also occur across all five sources under changing masks and strobes. A reference model written in the bench predicts `rd_data` and `irq` for every cycle.

// File: rtl/intr_regs_pkg.sv
// Shared constants and types for the interrupt register unit.
// Assumes byte addressing and a data word that is a whole number of bytes.
package intr_regs_pkg;
    parameter int unsigned SRC_N      = 5;
    parameter int unsigned WORD_W     = 32;
    parameter int unsigned GLOBAL_POS = 31;
    parameter int unsigned OFF_STATUS = 'h0C;
    parameter int unsigned OFF_MASK   = 'h10;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/intr_addr_dec.sv
// Address decoder: maps a byte address onto one of the two live registers.
// Assumes the full address is compared, so aliases are not decoded.
module intr_addr_dec
    import intr_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);

    // Select the register that the address names.
    always_comb begin
        if (addr == A_STATUS)    sel = SEL_STATUS;
        else if (addr == A_MASK) sel = SEL_MASK;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/intr_flag_bank.sv
// Sticky event flags with write-1-to-clear.
// A set from an event takes priority over a clear in the same cycle.
// Assumes the clear request is already qualified by address and strobe.
module intr_flag_bank #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        // Hold one flag: an event sets it, a clear drops it, otherwise it keeps its value.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[k] <= 1'b0;
            else if (evt[k]) flags[k] <= 1'b1;
            else if (clr[k]) flags[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_mask_reg.sv
// Mask register: per-source blocking bits plus one global blocking bit.
// Each bit is written only when the byte lane that holds it is strobed.
module intr_mask_reg #(
    parameter int unsigned N          = 5,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned GLOBAL_POS = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [WORD_W/8-1:0] wstrb,
    output logic [N-1:0]        mask_src,
    output logic                mask_glob
);
    localparam int unsigned GLANE = GLOBAL_POS / 8;

    for (genvar k = 0; k < N; k++) begin : g_src
        localparam int unsigned LANE = k / 8;
        // Store one per-source blocking bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                 mask_src[k] <= 1'b0;
            else if (we && wstrb[LANE]) mask_src[k] <= wdata[k];
        end
    end

    // Store the global blocking bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_glob <= 1'b0;
        else if (we && wstrb[GLANE]) mask_glob <= wdata[GLOBAL_POS];
    end
endmodule

// File: rtl/intr_irq_gen.sv
// Interrupt combiner: registered OR of the unmasked flags, gated by the global mask.
module intr_irq_gen #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask_src,
    input  logic         mask_glob,
    output logic         irq
);
    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (|(flags & ~mask_src)) & ~mask_glob;
    end
endmodule

// File: rtl/intr_regs_top.sv
// Interrupt status and mask register unit of a flash controller.
// Register port: single-cycle strobed writes and a registered read of one cycle latency.
// Assumes SRC_N fits inside byte lane 0 and GLOBAL_POS lies above SRC_N.
module intr_regs_top
    import intr_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N      = SRC_N,
    parameter int unsigned W      = WORD_W,
    parameter int unsigned GPOS   = GLOBAL_POS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   evt_i,
    input  logic           wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic [W/8-1:0] wr_strb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]   rd_data,
    output logic           irq
);
    localparam int unsigned STRB_W = W / 8;

    reg_sel_e    wsel, rsel;
    logic [N-1:0] flags, mask_src, clr;
    logic         mask_glob;
    logic [W-1:0] status_word, mask_word;
    logic         unused_bits;

    intr_addr_dec #(.ADDR_W(ADDR_W)) u_wdec (.addr(wr_addr), .sel(wsel));
    intr_addr_dec #(.ADDR_W(ADDR_W)) u_rdec (.addr(rd_addr), .sel(rsel));

    // Qualify the clear bits by write enable, address and byte lane.
    for (genvar k = 0; k < N; k++) begin : g_clr
        localparam int unsigned LANE = k / 8;
        assign clr[k] = wr_en && (wsel == SEL_STATUS) && wr_strb[LANE] && wr_data[k];
    end

    intr_flag_bank #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(clr), .flags(flags)
    );

    intr_mask_reg #(.N(N), .WORD_W(W), .GLOBAL_POS(GPOS)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && (wsel == SEL_MASK)),
        .wdata(wr_data), .wstrb(wr_strb),
        .mask_src(mask_src), .mask_glob(mask_glob)
    );

    intr_irq_gen #(.N(N)) u_irq (
        .clk(clk), .rst_n(rst_n), .flags(flags),
        .mask_src(mask_src), .mask_glob(mask_glob), .irq(irq)
    );

    // Build the read views, with reserved bits held at zero.
    always_comb begin
        status_word       = '0;
        status_word[N-1:0] = flags;
        mask_word         = '0;
        mask_word[N-1:0]  = mask_src;
        mask_word[GPOS]   = mask_glob;
    end

    // Register the read data selected by the read address.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else begin
            unique case (rsel)
                SEL_STATUS: rd_data <= status_word;
                SEL_MASK:   rd_data <= mask_word;
                default:    rd_data <= '0;
            endcase
        end
    end

    // Collect the write bits that only the mask block uses, or none uses.
    assign unused_bits = ^{wr_data[W-1:N], wr_strb[STRB_W-1:1]};
endmodule

// File: rtl/intr_regs_chk.sv
// Checker for the interrupt register unit, bound to the top module.
module intr_regs_chk
    import intr_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N      = SRC_N,
    parameter int unsigned W      = WORD_W,
    parameter int unsigned GPOS   = GLOBAL_POS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      evt_i,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [W-1:0]      wr_data,
    input logic [W/8-1:0]    wr_strb,
    input logic [N-1:0]      flags,
    input logic [N-1:0]      mask_src,
    input logic              mask_glob,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i))); // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(evt_i)) == '0)); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_STATUS && wr_strb[0] && evt_i == '0)
        |=> ((flags & $past(wr_data[N-1:0])) == '0)); // R3
    AST_GLOBAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mask_glob |=> !irq); // R6
    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~mask_src) == '0) |=> !irq); // R6
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_MASK) |=> ($stable(mask_src) && $stable(mask_glob))); // R9
endmodule

bind intr_regs_top intr_regs_chk #(.ADDR_W(ADDR_W), .N(N), .W(W), .GPOS(GPOS)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .flags(flags), .mask_src(mask_src),
    .mask_glob(mask_glob), .irq(irq)
);

// File: tb/sim_intr_regs_top.sv
// Bench: a behavioural reference model predicts rd_data and irq every cycle.
module sim_intr_regs_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  evt_i = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit [31:0] m_flags = 0;
    bit [31:0] m_mask  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_regs_top u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, advance the model, compare at the next falling edge.
    task automatic cyc(input string tag, input bit [4:0] ev, input bit we, input bit [7:0] wa,
                       input bit [31:0] wd, input bit [3:0] ws, input bit [7:0] ra);
        bit [31:0] e_rd;
        bit        e_irq;
        evt_i = ev; wr_en = we; wr_addr = wa; wr_data = wd; wr_strb = ws; rd_addr = ra;
        e_rd  = (ra == 8'h0C) ? m_flags : (ra == 8'h10) ? m_mask : 32'h0;
        e_irq = ((m_flags & ~m_mask & 32'h1F) != 0) && !m_mask[31];
        if (we && wa == 8'h0C && ws[0]) m_flags = m_flags & ~(wd & 32'h1F);
        m_flags = m_flags | {27'h0, ev};
        if (we && wa == 8'h10) begin
            if (ws[0]) m_mask = (m_mask & ~32'h1F) | (wd & 32'h1F);
            if (ws[3]) m_mask[31] = wd[31];
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " rd_data"}, rd_data, e_rd);
        check({tag, " irq"}, {31'h0, irq}, {31'h0, e_irq});
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 rd_data in reset", rd_data, 32'h0);
        check("R1 irq in reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        cyc("R1 status after reset", 5'h00, 0, 8'h00, 0, 4'h0, 8'h0C);
        cyc("R1 mask after reset",   5'h00, 0, 8'h00, 0, 4'h0, 8'h10);
        // R2: a pulse on transmit-full (bit 2) sets a sticky flag
        cyc("R2 pulse",  5'h04, 0, 8'h00, 0, 4'h0, 8'h0C);
        cyc("R2 sticky", 5'h00, 0, 8'h00, 0, 4'h0, 8'h0C);
        cyc("R6 irq up", 5'h00, 0, 8'h00, 0, 4'h0, 8'h0C);
        // R3: writing zeros keeps the flag, writing its 1 clears it
        cyc("R3 write zero", 5'h00, 1, 8'h0C, 32'h0, 4'hF, 8'h0C);
        cyc("R3 write one",  5'h00, 1, 8'h0C, 32'h4, 4'hF, 8'h0C);
        cyc("R3 readback",   5'h00, 0, 8'h00, 0, 4'h0, 8'h0C);
        // R4: event and clear on transfer-done (bit 0) in the same cycle
        cyc("R4 collide",    5'h01, 1, 8'h0C, 32'h1F, 4'h1, 8'h0C);
        cyc("R4 readback",   5'h00, 0, 8'h00, 0, 4'h0, 8'h0C);
        // R5: a write of all ones keeps only bits 4..0 and 31
        cyc("R5 mask all",   5'h00, 1, 8'h10, 32'hFFFF_FFFF, 4'hF, 8'h10);
        cyc("R5 readback",   5'h00, 0, 8'h00, 0, 4'h0, 8'h10);
        cyc("R6 masked",     5'h00, 0, 8'h00, 0, 4'h0, 8'h10);
        // R8: lane 0 only: the global bit keeps its value, source bits follow the data
        cyc("R8 lane0 only", 5'h00, 1, 8'h10, 32'h0000_0002, 4'h1, 8'h10);
        cyc("R8 readback",   5'h00, 0, 8'h00, 0, 4'h0, 8'h10);
        cyc("R8 lane3 only", 5'h00, 1, 8'h10, 32'h0000_0000, 4'h8, 8'h10);
        cyc("R6 global off", 5'h00, 0, 8'h00, 0, 4'h0, 8'h10);
        cyc("R6 irq after",  5'h00, 0, 8'h00, 0, 4'h0, 8'h0C);
        // R9: writes to other addresses touch nothing
        cyc("R9 other addr", 5'h00, 1, 8'h14, 32'hFFFF_FFFF, 4'hF, 8'h0C);
        cyc("R9 other addr", 5'h00, 1, 8'h00, 32'hFFFF_FFFF, 4'hF, 8'h10);
        cyc("R7 other read", 5'h00, 0, 8'h00, 0, 4'h0, 8'h18);
        cyc("R7 status read", 5'h00, 0, 8'h00, 0, 4'h0, 8'h0C);
        // Random mix of events, status clears and mask writes
        for (int i = 0; i < 2000; i++) begin
            bit [7:0] addrs [4] = '{8'h0C, 8'h10, 8'h14, 8'h0C};
            bit [4:0] ev = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
            cyc("R6 R7 random", ev, 1'($urandom), addrs[$urandom % 4], $urandom,
                4'($urandom), addrs[$urandom % 4]);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule